// File: doc/BRIEF.md
# Load/Store Data Formatter

This block sits between a load/store pipeline stage and the memory data path. It takes one 32-bit memory-access instruction word together with the value already read from its base register. From these it computes the effective address and checks its alignment. It then issues a request to either the scratchpad or main memory. For stores it packs the source register into a byte image with byte enables. For loads it waits for the returned data and turns it into a register value.

The memory side is byte-addressed from the effective address. Byte 0 of `mem_rdata` and `mem_wdata` is the byte at `mem_addr`, and `mem_be[k]` marks byte `mem_addr + k`. Load data is written into a scalar register (lane 0, bits 31:0) or into sixteen 32-bit lanes of a 512-bit vector register, using sign or zero extension. For vector stores the low byte, half-word or word of each lane is packed contiguously.

The control is a two-state sequencer. In `ST_IDLE` the block accepts an instruction and issues it in the same cycle. An accepted, aligned load takes the transition IDLE→LOAD_WAIT, which latches the opcode and destination index. `ST_LOAD_WAIT` ignores new instructions. A `mem_rvalid` pulse there delivers the formatted result and takes the transition LOAD_WAIT→IDLE. Stores, traps and ignored opcodes keep the block in `ST_IDLE`.

Top module: `lsf_top`

## Requirements
- R1: The opcode is read from instruction bits 29:24. The data register index in bits 23:18 of a load is returned on `ld_dest` together with its result.
- R2: The effective address on `mem_addr` is `base_val` plus the offset field in bits 11:3. The offset is sign-extended from 9 bits, so 9'h1FF adds -1.
- R3: Scalar loads write lane 0 and clear all other lanes. The opcodes are:
  - 0: byte, sign-extended.
  - 1: half-word, sign-extended.
  - 2: word.
  - 4: byte, zero-extended.
  - 5: half-word, zero-extended.
- R4: Vector loads place element i of the returned data into lane i (bits 32i+31:32i) for all 16 lanes. The opcodes are:
  - 7: bytes, sign-extended.
  - 8: half-words, sign-extended.
  - 9: words.
  - 11: bytes, zero-extended.
  - 12: half-words, zero-extended.
- R5: Opcode 13 loads eight words, zero-extended, into lanes 0 to 7 and clears lanes 8 to 15.
- R6: Scalar stores take their data from lane 0. The opcodes are 32 (byte), 33 (half-word) and 34 (word). They drive `mem_we`, place the data in the low bytes of `mem_wdata`, and set exactly 1, 2 or 4 low bits of `mem_be`.
- R7: Vector stores pack the low byte, low half-word or whole word of every lane contiguously. The opcodes are 36 (bytes), 37 (half-words) and 38 (words). `mem_be` has 16, 32 or 64 low bits set. `mem_be` is zero whenever no write is issued.
- R8: A half-word access needs an even address and a word access needs an address that is a multiple of 4. For vector accesses this is the element size. A misaligned access raises `trap` for one cycle and issues no request. `trap_spm` then reports instruction bit 1.
- R9: `mem_spm` follows instruction bit 1 on every issued request: 1 selects the scratchpad, 0 selects main memory.
- R10: Any opcode not listed in R3 to R7 (including 16 and 42) is ignored. It produces no request, no trap and no load result.
- R11: After a load is issued, `busy` is high and further instructions are ignored until `mem_rvalid` arrives. `ld_valid` is raised in that same cycle, and the block returns to idle. A `mem_rvalid` seen while idle produces no result.
- R12: During and right after reset the block is idle. `busy`, `ld_valid`, `mem_req` (with `op_valid` low) and `trap` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Instruction presented this cycle |
| op_word | input | 32 | Memory-access instruction word |
| base_val | input | ADDR_W | Value of the base register |
| st_src | input | LANES*LANE_W | Store source register (scalar in lane 0) |
| busy | output | 1 | Load outstanding; instructions ignored |
| mem_req | output | 1 | Memory request issued this cycle |
| mem_we | output | 1 | Request is a write |
| mem_spm | output | 1 | Request targets the scratchpad |
| mem_addr | output | ADDR_W | Effective address |
| mem_be | output | LANES*LANE_W/8 | Byte enables from the effective address |
| mem_wdata | output | LANES*LANE_W | Packed store image |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | LANES*LANE_W | Read bytes starting at the effective address |
| ld_valid | output | 1 | Load result valid |
| ld_dest | output | 6 | Destination register index of the result |
| ld_data | output | LANES*LANE_W | Formatted register value |
| trap | output | 1 | Misaligned access rejected |
| trap_spm | output | 1 | Trap cause: 1 scratchpad, 0 load/store unit |

## Verification
The bench builds the block with its default parameters: sixteen 32-bit lanes and a 32-bit address. With these values a vector word access spans the whole 64-byte data path and lane 15's top bits are exercised. The eight-word load's boundary falls between lanes 7 and 8. Using the real lane count lets every opcode's byte-enable width, from 1 to 64 bits, be compared against the widest case. Random offsets of both signs, mixed with forced alignments, reach each misalignment pattern for each element size.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2
    } elem_sz_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_LOAD_WAIT = 1'b1
    } fsm_e;

    typedef struct packed {
        logic     legal;
        logic     is_store;
        logic     is_vec;
        logic     half_cnt;
        logic     sgn;
        elem_sz_e sz;
    } acc_desc_t;

    function automatic acc_desc_t mk_desc(logic st, logic vec, logic half,
                                          logic sgn, elem_sz_e sz);
        acc_desc_t d;
        d.legal    = 1'b1;
        d.is_store = st;
        d.is_vec   = vec;
        d.half_cnt = half;
        d.sgn      = sgn;
        d.sz       = sz;
        return d;
    endfunction

endpackage

// File: rtl/lsf_decode.sv
module lsf_decode
    import lsf_pkg::*;
(
    input  logic [5:0] op,
    output acc_desc_t  desc
);

    always_comb begin
        desc = '0;
        case (op)
            6'd0:  desc = mk_desc(1'b0, 1'b0, 1'b0, 1'b1, SZ_B);
            6'd1:  desc = mk_desc(1'b0, 1'b0, 1'b0, 1'b1, SZ_H);
            6'd2:  desc = mk_desc(1'b0, 1'b0, 1'b0, 1'b0, SZ_W);
            6'd4:  desc = mk_desc(1'b0, 1'b0, 1'b0, 1'b0, SZ_B);
            6'd5:  desc = mk_desc(1'b0, 1'b0, 1'b0, 1'b0, SZ_H);
            6'd7:  desc = mk_desc(1'b0, 1'b1, 1'b0, 1'b1, SZ_B);
            6'd8:  desc = mk_desc(1'b0, 1'b1, 1'b0, 1'b1, SZ_H);
            6'd9:  desc = mk_desc(1'b0, 1'b1, 1'b0, 1'b0, SZ_W);
            6'd11: desc = mk_desc(1'b0, 1'b1, 1'b0, 1'b0, SZ_B);
            6'd12: desc = mk_desc(1'b0, 1'b1, 1'b0, 1'b0, SZ_H);
            6'd13: desc = mk_desc(1'b0, 1'b1, 1'b1, 1'b0, SZ_W);
            6'd32: desc = mk_desc(1'b1, 1'b0, 1'b0, 1'b0, SZ_B);
            6'd33: desc = mk_desc(1'b1, 1'b0, 1'b0, 1'b0, SZ_H);
            6'd34: desc = mk_desc(1'b1, 1'b0, 1'b0, 1'b0, SZ_W);
            6'd36: desc = mk_desc(1'b1, 1'b1, 1'b0, 1'b0, SZ_B);
            6'd37: desc = mk_desc(1'b1, 1'b1, 1'b0, 1'b0, SZ_H);
            6'd38: desc = mk_desc(1'b1, 1'b1, 1'b0, 1'b0, SZ_W);
            default: desc = '0;
        endcase
    end

endmodule

// File: rtl/lsf_load_fmt.sv
module lsf_load_fmt
    import lsf_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int LANE_W = 32
) (
    input  acc_desc_t                  desc,
    input  logic [LANES*LANE_W-1:0]    raw,
    output logic [LANES*LANE_W-1:0]    lanes_out
);

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic unused_desc;
    assign unused_desc = ^{desc.legal, desc.is_store};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit UPPER = (g >= LANES / 2);
        localparam bit FIRST = (g == 0);
        logic [LANE_W-1:0] ext;
        logic              on;

        always_comb begin
            if (!desc.is_vec) on = FIRST;
            else              on = !(desc.half_cnt && UPPER);
            case (desc.sz)
                SZ_B: ext = {{(LANE_W-BYTE_W){desc.sgn & raw[g*BYTE_W+BYTE_W-1]}},
                             raw[g*BYTE_W +: BYTE_W]};
                SZ_H: ext = {{(LANE_W-HALF_W){desc.sgn & raw[g*HALF_W+HALF_W-1]}},
                             raw[g*HALF_W +: HALF_W]};
                default: ext = raw[g*LANE_W +: LANE_W];
            endcase
        end

        assign lanes_out[g*LANE_W +: LANE_W] = on ? ext : '0;
    end

endmodule

// File: rtl/lsf_store_pack.sv
module lsf_store_pack
    import lsf_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int LANE_W = 32
) (
    input  acc_desc_t                    desc,
    input  logic [LANES*LANE_W-1:0]      src,
    output logic [LANES*LANE_W-1:0]      wdata,
    output logic [LANES*LANE_W/8-1:0]    be
);

    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 16;
    localparam int LANE_B   = LANE_W / BYTE_W;

    logic unused_desc;
    assign unused_desc = ^{desc.legal, desc.is_store, desc.half_cnt, desc.sgn};

    int cnt;
    assign cnt = desc.is_vec ? LANES : 1;

    always_comb begin
        wdata = '0;
        be    = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < cnt) begin
                case (desc.sz)
                    SZ_B: begin
                        wdata[i*BYTE_W +: BYTE_W] = src[i*LANE_W +: BYTE_W];
                        be[i] = 1'b1;
                    end
                    SZ_H: begin
                        wdata[i*HALF_W +: HALF_W] = src[i*LANE_W +: HALF_W];
                        be[i*2 +: 2] = 2'b11;
                    end
                    default: begin
                        wdata[i*LANE_W +: LANE_W] = src[i*LANE_W +: LANE_W];
                        be[i*LANE_B +: LANE_B] = '1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/lsf_top.sv
module lsf_top
    import lsf_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int LANE_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [31:0]                 op_word,
    input  logic [ADDR_W-1:0]           base_val,
    input  logic [LANES*LANE_W-1:0]     st_src,
    output logic                        busy,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic                        mem_spm,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [LANES*LANE_W/8-1:0]   mem_be,
    output logic [LANES*LANE_W-1:0]     mem_wdata,
    input  logic                        mem_rvalid,
    input  logic [LANES*LANE_W-1:0]     mem_rdata,
    output logic                        ld_valid,
    output logic [5:0]                  ld_dest,
    output logic [LANES*LANE_W-1:0]     ld_data,
    output logic                        trap,
    output logic                        trap_spm
);

    localparam int DW      = LANES * LANE_W;
    localparam int BW      = DW / 8;
    localparam int OPC_LO  = 24;
    localparam int RD_LO   = 18;
    localparam int OFF_LO  = 3;
    localparam int SPM_BIT = 1;

    logic unused_bits;
    assign unused_bits = ^{op_word[31:30], op_word[17:12], op_word[2], op_word[0]};

    logic [5:0] f_op;
    logic [5:0] f_rd;
    logic [OFF_W-1:0] f_off;
    assign f_op  = op_word[OPC_LO +: 6];
    assign f_rd  = op_word[RD_LO +: 6];
    assign f_off = op_word[OFF_LO +: OFF_W];

    acc_desc_t new_d, pend_d;
    fsm_e      state_q, state_d;
    logic [5:0] pend_op_q, pend_rd_q;

    lsf_decode u_dec_new  (.op(f_op),      .desc(new_d));
    lsf_decode u_dec_pend (.op(pend_op_q), .desc(pend_d));

    logic [DW-1:0] pk_wdata;
    logic [BW-1:0] pk_be;
    logic [DW-1:0] fmt_data;

    lsf_store_pack #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
        .desc (new_d),
        .src  (st_src),
        .wdata(pk_wdata),
        .be   (pk_be)
    );

    lsf_load_fmt #(.LANES(LANES), .LANE_W(LANE_W)) u_fmt (
        .desc     (pend_d),
        .raw      (mem_rdata),
        .lanes_out(fmt_data)
    );

    logic [ADDR_W-1:0] ea;
    assign ea = base_val + {{(ADDR_W-OFF_W){f_off[OFF_W-1]}}, f_off};

    logic misalign;
    always_comb begin
        case (new_d.sz)
            SZ_H:    misalign = ea[0];
            SZ_W:    misalign = |ea[1:0];
            default: misalign = 1'b0;
        endcase
    end

    logic accept, go;
    assign accept = (state_q == ST_IDLE) && op_valid && new_d.legal;
    assign go     = accept && !misalign;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (go && !new_d.is_store) state_d = ST_LOAD_WAIT;
            ST_LOAD_WAIT: if (mem_rvalid)            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pend_op_q <= '0;
            pend_rd_q <= '0;
        end else begin
            state_q <= state_d;
            if (go && !new_d.is_store) begin
                pend_op_q <= f_op;
                pend_rd_q <= f_rd;
            end
        end
    end

    always_comb begin
        busy      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_spm   = 1'b0;
        mem_addr  = ea;
        mem_be    = '0;
        mem_wdata = '0;
        ld_valid  = 1'b0;
        ld_dest   = pend_rd_q;
        ld_data   = '0;
        trap      = 1'b0;
        trap_spm  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                mem_req  = go;
                mem_spm  = go && op_word[SPM_BIT];
                trap     = accept && misalign;
                trap_spm = accept && misalign && op_word[SPM_BIT];
                if (go && new_d.is_store) begin
                    mem_we    = 1'b1;
                    mem_be    = pk_be;
                    mem_wdata = pk_wdata;
                end
            end
            ST_LOAD_WAIT: begin
                busy     = 1'b1;
                ld_valid = mem_rvalid;
                if (mem_rvalid) ld_data = fmt_data;
            end
        endcase
    end

endmodule

// File: rtl/lsf_chk.sv
module lsf_chk #(
    parameter int BW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [BW-1:0] mem_be,
    input logic          mem_rvalid,
    input logic          ld_valid,
    input logic          trap
);

    AST_TRAP_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !mem_req); // R8

    AST_BUSY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mem_req && !trap)); // R11

    AST_LOAD_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> busy); // R11

    AST_WAIT_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(mem_req && !mem_we)); // R11

    AST_RESULT_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> (busy && mem_rvalid)); // R11

    AST_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rvalid) |=> !busy); // R11

    AST_BE_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_be != '0) && ((mem_be & (mem_be + BW'(1))) == '0))); // R6

    AST_BE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_be == '0)); // R7

endmodule

bind lsf_top lsf_chk #(.BW(LANES*LANE_W/8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_rvalid(mem_rvalid),
    .ld_valid  (ld_valid),
    .trap      (trap)
);

// File: tb/sim_lsf_top.sv
`timescale 1ns/1ps
module sim_lsf_top;

    localparam int DW = 512;
    localparam int BW = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           op_valid = 1'b0;
    logic [31:0]    op_word = '0;
    logic [31:0]    base_val = '0;
    logic [DW-1:0]  st_src = '0;
    logic           busy, mem_req, mem_we, mem_spm;
    logic [31:0]    mem_addr;
    logic [BW-1:0]  mem_be;
    logic [DW-1:0]  mem_wdata;
    logic           mem_rvalid = 1'b0;
    logic [DW-1:0]  mem_rdata = '0;
    logic           ld_valid;
    logic [5:0]     ld_dest;
    logic [DW-1:0]  ld_data;
    logic           trap, trap_spm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lsf_top u0 (.*);

    task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int op, int rd, logic [8:0] off, bit spm);
        return {2'b00, 6'(op), 6'(rd), 6'd5, off, 1'b0, spm, 1'b0};
    endfunction

    function automatic bit legal(int op);
        case (op)
            0, 1, 2, 4, 5, 7, 8, 9, 11, 12, 13, 32, 33, 34, 36, 37, 38: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int esize(int op);
        case (op)
            1, 5, 8, 12, 33, 37: return 2;
            2, 9, 13, 34, 38:    return 4;
            default:             return 1;
        endcase
    endfunction

    function automatic logic [DW-1:0] exp_ld(int op, logic [DW-1:0] r);
        logic [DW-1:0] v = '0;
        case (op)
            0: v[31:0] = {{24{r[7]}}, r[7:0]};
            1: v[31:0] = {{16{r[15]}}, r[15:0]};
            2: v[31:0] = r[31:0];
            4: v[31:0] = {24'd0, r[7:0]};
            5: v[31:0] = {16'd0, r[15:0]};
            7:  for (int i = 0; i < 16; i++) v[i*32 +: 32] = {{24{r[i*8+7]}}, r[i*8 +: 8]};
            8:  for (int i = 0; i < 16; i++) v[i*32 +: 32] = {{16{r[i*16+15]}}, r[i*16 +: 16]};
            9:  v = r;
            11: for (int i = 0; i < 16; i++) v[i*32 +: 32] = {24'd0, r[i*8 +: 8]};
            12: for (int i = 0; i < 16; i++) v[i*32 +: 32] = {16'd0, r[i*16 +: 16]};
            13: v[255:0] = r[255:0];
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [DW-1:0] exp_wd(int op, logic [DW-1:0] s);
        logic [DW-1:0] v = '0;
        case (op)
            32: v[7:0]  = s[7:0];
            33: v[15:0] = s[15:0];
            34: v[31:0] = s[31:0];
            36: for (int i = 0; i < 16; i++) v[i*8 +: 8]   = s[i*32 +: 8];
            37: for (int i = 0; i < 16; i++) v[i*16 +: 16] = s[i*32 +: 16];
            default: v = s;
        endcase
        return v;
    endfunction

    function automatic logic [BW-1:0] exp_be(int op);
        case (op)
            32: return 64'h1;
            33: return 64'h3;
            34: return 64'hF;
            36: return 64'hFFFF;
            37: return 64'hFFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    function automatic string ld_tag(int op);
        if (op < 7) return "R3";
        if (op == 13) return "R5";
        return "R4";
    endfunction

    task automatic run_op(logic [31:0] w, logic [31:0] b, logic [DW-1:0] s, logic [DW-1:0] r);
        int op = int'(w[29:24]);
        logic [31:0] ea = b + {{23{w[11]}}, w[11:3]};
        bit st = (op >= 32);
        int es = esize(op);
        bit mis = (es == 2 && ea[0]) || (es == 4 && ea[1:0] != 2'b00);
        @(negedge clk);
        op_valid = 1'b1; op_word = w; base_val = b; st_src = s;
        #1;
        if (!legal(op)) begin
            chk(!mem_req && !trap, "R10", "ignored opcode", {mem_req, trap}, '0);
        end else if (mis) begin
            chk(trap && !mem_req, "R8", "misaligned trap", {trap, mem_req}, 2'b10);
            chk(trap_spm == w[1], "R8", "trap cause", trap_spm, w[1]);
        end else begin
            chk(mem_req && !trap, "R8", "aligned issues", {mem_req, trap}, 2'b10);
            chk(mem_addr == ea, "R2", "effective address", mem_addr, ea);
            chk(mem_spm == w[1], "R9", "routing", mem_spm, w[1]);
            chk(mem_we == st, "R6", "write flag", mem_we, st);
            if (st) begin
                chk(mem_be == exp_be(op), (op < 36) ? "R6" : "R7", "byte enables", mem_be, exp_be(op));
                chk(mem_wdata == exp_wd(op, s), (op < 36) ? "R6" : "R7", "store image",
                    mem_wdata, exp_wd(op, s));
            end else begin
                chk(mem_be == '0, "R7", "no enables on read", mem_be, '0);
            end
        end
        @(negedge clk);
        op_valid = 1'b0;
        if (legal(op) && !mis && !st) begin
            chk(busy, "R11", "busy after load", busy, 1);
            mem_rvalid = 1'b1; mem_rdata = r;
            #1;
            chk(ld_valid, "R11", "result valid", ld_valid, 1);
            chk(ld_dest == w[23:18], "R1", "destination", ld_dest, w[23:18]);
            chk(ld_data == exp_ld(op, r), ld_tag(op), "load data", ld_data, exp_ld(op, r));
            @(negedge clk);
            mem_rvalid = 1'b0;
            #1;
            chk(!busy, "R11", "back to idle", busy, 0);
        end
    endtask

    function automatic logic [DW-1:0] rnd512();
        logic [DW-1:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ops[17] = '{0, 1, 2, 4, 5, 7, 8, 9, 11, 12, 13, 32, 33, 34, 36, 37, 38};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !ld_valid && !mem_req && !trap, "R12", "reset state",
            {busy, ld_valid, mem_req, trap}, '0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(!busy && !ld_valid && !mem_req && !trap, "R12", "after reset",
            {busy, ld_valid, mem_req, trap}, '0);

        // directed corner cases
        run_op(mk(0, 7, 9'd0, 0), 32'h100, '0, {504'd0, 8'h80});          // R3 sign byte
        run_op(mk(4, 8, 9'd0, 0), 32'h100, '0, {504'd0, 8'h80});          // R3 zero byte
        run_op(mk(13, 9, 9'd4, 1), 32'h200, '0, '1);                      // R5 upper lanes clear
        run_op(mk(8, 10, 9'd2, 0), 32'h300, '0, rnd512());                // R8 vector half at ea%4=2
        run_op(mk(34, 0, 9'h1FF, 1), 32'h101, rnd512(), '0);              // R2 offset -1
        run_op(mk(34, 0, 9'd2, 1), 32'h100, rnd512(), '0);                // R8 misaligned word, spm
        run_op(mk(33, 0, 9'd1, 0), 32'h100, rnd512(), '0);                // R8 misaligned half, lsu
        run_op(mk(16, 3, 9'd0, 1), 32'h100, rnd512(), rnd512());          // R10 gather ignored
        run_op(mk(42, 3, 9'd0, 1), 32'h100, rnd512(), rnd512());          // R10 scatter ignored
        run_op(mk(36, 0, 9'd0, 0), 32'h400, rnd512(), '0);                // R7 byte pack
        run_op(mk(37, 0, 9'd0, 1), 32'h400, rnd512(), '0);                // R7 half pack

        // R11: instruction while waiting is ignored
        @(negedge clk);
        op_valid = 1'b1; op_word = mk(9, 12, 9'd0, 0); base_val = 32'h500;
        @(negedge clk);
        op_word = mk(34, 0, 9'd0, 0);
        #1;
        chk(busy && !mem_req && !trap, "R11", "ignored while busy", {busy, mem_req, trap}, 3'b100);
        @(negedge clk);
        op_valid = 1'b0; mem_rvalid = 1'b1; mem_rdata = {16{32'hCAFE_F00D}};
        #1;
        chk(ld_valid && ld_dest == 6'd12, "R11", "result after wait", {ld_valid, ld_dest}, {1'b1, 6'd12});
        @(negedge clk);
        #1;
        chk(!ld_valid && !busy, "R11", "rvalid while idle", {ld_valid, busy}, '0);
        mem_rvalid = 1'b0;

        // constrained random
        for (int n = 0; n < 400; n++) begin
            int op = ($urandom % 8 == 0) ? int'($urandom % 64) : ops[$urandom % 17];
            logic [8:0] off = 9'($urandom);
            logic [31:0] b = $urandom;
            logic [31:0] ea = b + {{23{off[8]}}, off};
            if ($urandom % 4 != 0) b = b - {30'd0, ea[1:0]};
            run_op(mk(op, int'($urandom % 64), off, 1'($urandom)), b, rnd512(), rnd512());
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule